// File: doc/BRIEF.md
# Multi-channel serial ADC capture

This block receives the serial outputs of up to eight dual-channel 16-bit converter modules and turns them into one parallel sample vector. Each converter channel drives its own serial lane. All lanes are sampled with a single bit clock, the one taken from module 0. Each lane is sampled on both clock edges, so one 16-bit word arrives in eight clock periods. Word boundaries come from a frame signal. The block checks that frame periods have the right length before it releases any data. After that, at every frame boundary it latches the words of all active channels together and raises a one-cycle valid strobe.

Every module also drives a frame signal, and the redundant ones are not used for sampling. With redundancy enabled and at least three modules active, a majority vote over the frames of modules 0, 1 and 2 gives the reference frame, so one defective frame line is outvoted. Each active module whose frame differs from the reference sets a sticky diagnostic flag, and software can clear these flags. A parameter sets the number of lanes per channel. Extra lanes shorten the word period, and each lane then carries every LANES-th bit position.

Top module: `adc_capture_top`

## Requirements
- R1: After reset, `sample_valid`, `locked` and `frame_err` are 0 and all `mismatch` bits are 0.
- R2: Each lane is sampled at the falling edge and then at the rising edge of `clk`. The falling-edge bit comes first. A word's most significant bit is its first bit. A word is the 16 bits of the 8 clock periods between two frame boundaries.
- R3: A frame boundary is a rising edge of `clk` at which the reference frame is sampled high after being low at the previous rising edge. At a boundary, while locked, the word that just ended is latched for every channel. `sample_valid` is then high for exactly one cycle. Channel c of module m appears at `sample_out[(2*m+c)*16 +: 16]`.
- R4: `locked` rises and the first `sample_valid` appears only at the boundary that closes the second of two consecutive frame periods of exactly 8 clock cycles. No word is output before that.
- R5: A boundary that comes fewer than 8 cycles after the previous one has four effects. It raises `frame_err` for one cycle and clears `locked`. It outputs no word. It starts a new alignment from that boundary.
- R6: If no boundary has come 8 cycles after the last one, `frame_err` pulses for one cycle and `locked` clears. The block then waits for the next boundary.
- R7: Module m is active when m = 0 or m < `mod_count`. Inactive modules give zero words in `sample_out`, and their `mismatch` bits never set.
- R8: With `vote_en` = 1 and `mod_count` >= 3, the reference frame is the majority of the frames of modules 0, 1 and 2. Otherwise it is the frame of module 0.
- R9: `mismatch[m]` sets when active module m's frame differs from the reference at a rising edge. It then stays set.
- R10: `mismatch_clr` = 1 at a rising edge clears all `mismatch` bits. The clear wins over a set at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of module 0 |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_count | input | 4 | Number of active modules |
| vote_en | input | 1 | Enables majority voting of the frame |
| mismatch_clr | input | 1 | Clears the sticky mismatch flags |
| lane_in | input | 16 | Serial lanes, channel c of module m at bit 2*m+c |
| frame_in | input | 8 | Frame signal of each module |
| sample_out | output | 256 | Latched words of all channels |
| sample_valid | output | 1 | One-cycle strobe for a new sample vector |
| locked | output | 1 | Frame alignment achieved |
| frame_err | output | 1 | One-cycle pulse on a frame period of wrong length |
| mismatch | output | 8 | Sticky per-module frame disagreement flags |

## Verification
The bench sends each word with known bit values. A design that reversed the order of the two edges or sent the least significant bit first would return scrambled words. A design that latched at the wrong boundary would return the following word or half of the neighbouring one. Short and long frame periods are injected around a locked stream. A design that failed to drop lock, output a word at a bad boundary, or relocked after a single good period would produce the wrong count or the wrong sequence of captured words. Frame lines are inverted one at a time with voting on and off, and with too few modules active. A wrong choice of reference, or flags raised by inactive modules, shows up as a different `mismatch` pattern. The bench also checks that a clear issued while a disagreement persists still empties the flags for that cycle.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    typedef enum logic [1:0] {
        ALN_SEEK   = 2'd0,
        ALN_COUNT  = 2'd1,
        ALN_LOCKED = 2'd2
    } aln_state_e;

endpackage

// File: rtl/adc_lane_deser.sv
// Double-edge deserializer for one converter channel.
module adc_lane_deser #(
    parameter int SAMPLE_W = 16,
    parameter int LANES    = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES-1:0]    lane,
    output logic [SAMPLE_W-1:0] word
);
    localparam int SHIFT = 2 * LANES;

    typedef struct packed {
        logic [SAMPLE_W-1:0] sr;
    } deser_st_t;

    logic [LANES-1:0] fall_q;
    deser_st_t        st_d, st_q;

    // falling-edge half of each bit period
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= lane;
    end

    // falling-edge bits precede rising-edge bits in the serial order
    always_comb begin
        st_d    = st_q;
        st_d.sr = {st_q.sr[SAMPLE_W-SHIFT-1:0], fall_q, lane};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.sr;

endmodule

// File: rtl/adc_frame_vote.sv
// Reference frame selection and sticky per-module disagreement flags.
module adc_frame_vote #(
    parameter int NUM_MOD = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MOD-1:0] frame_in,
    input  logic [NUM_MOD-1:0] active,
    input  logic               vote_mode,
    input  logic               mismatch_clr,
    output logic               ref_frame,
    output logic [NUM_MOD-1:0] mismatch
);
    typedef struct packed {
        logic [NUM_MOD-1:0] flags;
    } vote_st_t;

    vote_st_t st_d, st_q;
    logic     majority;

    generate
        if (NUM_MOD >= 3) begin : g_maj
            assign majority = (frame_in[0] & frame_in[1]) |
                              (frame_in[0] & frame_in[2]) |
                              (frame_in[1] & frame_in[2]);
        end else begin : g_single
            assign majority = frame_in[0];
        end
    endgenerate

    assign ref_frame = vote_mode ? majority : frame_in[0];

    always_comb begin
        st_d = st_q;
        if (mismatch_clr) begin
            st_d.flags = '0;
        end else begin
            st_d.flags = st_q.flags | (active & (frame_in ^ {NUM_MOD{ref_frame}}));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mismatch = st_q.flags;

endmodule

// File: rtl/adc_frame_align.sv
// Frame period checker: lock after LOCK_PERIODS good periods, error on bad length.
module adc_frame_align
    import adc_cap_pkg::*;
#(
    parameter int PERIOD       = 8,
    parameter int LOCK_PERIODS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_frame,
    output logic emit,
    output logic locked,
    output logic frame_err
);
    localparam int CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int GOOD_W = $clog2(LOCK_PERIODS + 1);

    typedef struct packed {
        aln_state_e        state;
        logic              prev;
        logic [CNT_W-1:0]  cnt;
        logic [GOOD_W-1:0] good;
        logic              err;
    } aln_st_t;

    aln_st_t st_d, st_q;
    logic    rise;
    logic    at_end;

    always_comb begin
        st_d      = st_q;
        emit      = 1'b0;
        rise      = ref_frame & ~st_q.prev;
        at_end    = (st_q.cnt == CNT_W'(PERIOD - 1));
        st_d.prev = ref_frame;
        st_d.err  = 1'b0;
        case (st_q.state)
            ALN_SEEK: begin
                if (rise) begin
                    st_d.state = ALN_COUNT;
                    st_d.cnt   = '0;
                    st_d.good  = '0;
                end
            end
            default: begin
                if (rise) begin
                    st_d.cnt = '0;
                    if (at_end) begin
                        if (st_q.state == ALN_LOCKED) begin
                            emit = 1'b1;
                        end else if (st_q.good == GOOD_W'(LOCK_PERIODS - 1)) begin
                            st_d.state = ALN_LOCKED;
                            emit       = 1'b1;
                        end else begin
                            st_d.good = st_q.good + 1'b1;
                        end
                    end else begin
                        st_d.err   = 1'b1;
                        st_d.state = ALN_COUNT;
                        st_d.good  = '0;
                    end
                end else if (at_end) begin
                    st_d.err   = 1'b1;
                    st_d.state = ALN_SEEK;
                    st_d.good  = '0;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: ALN_SEEK, default: '0};
        else        st_q <= st_d;
    end

    assign locked    = (st_q.state == ALN_LOCKED);
    assign frame_err = st_q.err;

endmodule

// File: rtl/adc_capture_top.sv
module adc_capture_top #(
    parameter int NUM_MOD      = 8,
    parameter int CH_PER_MOD   = 2,
    parameter int SAMPLE_W     = 16,
    parameter int LANES        = 1,
    parameter int LOCK_PERIODS = 2,
    localparam int NUM_CH      = NUM_MOD * CH_PER_MOD,
    localparam int LANE_W      = NUM_CH * LANES,
    localparam int OUT_W       = NUM_CH * SAMPLE_W,
    localparam int MCNT_W      = $clog2(NUM_MOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MCNT_W-1:0] mod_count,
    input  logic              vote_en,
    input  logic              mismatch_clr,
    input  logic [LANE_W-1:0] lane_in,
    input  logic [NUM_MOD-1:0] frame_in,
    output logic [OUT_W-1:0]  sample_out,
    output logic              sample_valid,
    output logic              locked,
    output logic              frame_err,
    output logic [NUM_MOD-1:0] mismatch
);
    localparam int PERIOD = SAMPLE_W / (2 * LANES);

    typedef struct packed {
        logic [OUT_W-1:0] samples;
        logic             valid;
    } cap_st_t;

    cap_st_t             st_d, st_q;
    logic [SAMPLE_W-1:0] words [NUM_CH];
    logic [NUM_MOD-1:0]  active;
    logic                vote_mode;
    logic                ref_frame;
    logic                emit;

    always_comb begin
        for (int m = 0; m < NUM_MOD; m++) begin
            active[m] = (m == 0) || (m < int'(mod_count));
        end
    end

    assign vote_mode = vote_en && (NUM_MOD >= 3) && (int'(mod_count) >= 3);

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            adc_lane_deser #(
                .SAMPLE_W (SAMPLE_W),
                .LANES    (LANES)
            ) i_deser (
                .clk  (clk),
                .rst_n(rst_n),
                .lane (lane_in[g*LANES +: LANES]),
                .word (words[g])
            );
        end
    endgenerate

    adc_frame_vote #(
        .NUM_MOD(NUM_MOD)
    ) i_vote (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_in    (frame_in),
        .active      (active),
        .vote_mode   (vote_mode),
        .mismatch_clr(mismatch_clr),
        .ref_frame   (ref_frame),
        .mismatch    (mismatch)
    );

    adc_frame_align #(
        .PERIOD      (PERIOD),
        .LOCK_PERIODS(LOCK_PERIODS)
    ) i_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_frame(ref_frame),
        .emit     (emit),
        .locked   (locked),
        .frame_err(frame_err)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = emit;
        if (emit) begin
            for (int m = 0; m < NUM_MOD; m++) begin
                for (int c = 0; c < CH_PER_MOD; c++) begin
                    st_d.samples[(m*CH_PER_MOD + c)*SAMPLE_W +: SAMPLE_W] =
                        active[m] ? words[m*CH_PER_MOD + c] : '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_out   = st_q.samples;
    assign sample_valid = st_q.valid;

endmodule

// File: rtl/adc_capture_chk.sv
module adc_capture_chk #(
    parameter int NUM_MOD = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mismatch_clr,
    input logic               sample_valid,
    input logic               locked,
    input logic               frame_err,
    input logic [NUM_MOD-1:0] mismatch
);
    // R3
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R4
    valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> locked);

    // R4
    lock_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> sample_valid);

    // R5
    err_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> (!locked && !sample_valid));

    // R9
    mismatch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mismatch_clr |=> ((mismatch & $past(mismatch)) == $past(mismatch)));

    // R10
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_clr |=> (mismatch == '0));

endmodule

bind adc_capture_top adc_capture_chk #(
    .NUM_MOD(NUM_MOD)
) i_adc_capture_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mismatch_clr(mismatch_clr),
    .sample_valid(sample_valid),
    .locked      (locked),
    .frame_err   (frame_err),
    .mismatch    (mismatch)
);

// File: tb/test_adc_capture_top.sv
module test_adc_capture_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   mod_count = 4'd8;
    logic         vote_en = 1'b0;
    logic         mismatch_clr = 1'b0;
    logic [15:0]  lane_in = '0;
    logic [7:0]   frame_in = '0;
    logic [255:0] sample_out;
    logic         sample_valid;
    logic         locked;
    logic         frame_err;
    logic [7:0]   mismatch;

    int tests = 0;
    int fails = 0;
    int cap_n = 0;
    int err_n = 0;
    int dbl_valid = 0;
    logic prev_valid = 1'b0;
    logic [255:0] cap [16];

    always #2 clk = ~clk;

    adc_capture_top i_adc_capture_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .mod_count   (mod_count),
        .vote_en     (vote_en),
        .mismatch_clr(mismatch_clr),
        .lane_in     (lane_in),
        .frame_in    (frame_in),
        .sample_out  (sample_out),
        .sample_valid(sample_valid),
        .locked      (locked),
        .frame_err   (frame_err),
        .mismatch    (mismatch)
    );

    // output monitor, sampling one time unit after each rising edge
    always @(posedge clk) begin
        #1;
        if (sample_valid) begin
            if (cap_n < 16) cap[cap_n] = sample_out;
            cap_n++;
            if (prev_valid) dbl_valid++;
        end
        if (frame_err) err_n++;
        prev_valid = sample_valid;
    end

    function automatic logic [15:0] wv(input int seed, input int ch);
        return 16'((seed * 40503 + ch * 4099 + 23100) & 32'hFFFF);
    endfunction

    function automatic logic [255:0] exp_vec(input int seed, input int cnt);
        logic [255:0] v = '0;
        for (int m = 0; m < 8; m++) begin
            for (int c = 0; c < 2; c++) begin
                if (m == 0 || m < cnt) v[(m*2+c)*16 +: 16] = wv(seed, m*2+c);
            end
        end
        return v;
    endfunction

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lane_in = '0;
        frame_in = '0;
        mismatch_clr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cap_n = 0;
        err_n = 0;
        dbl_valid = 0;
        prev_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            lane_in = '0;
            frame_in = '0;
        end
    endtask

    // one word period of len clock cycles; bad inverts frames of selected modules
    task automatic send(input int seed, input int len, input logic [7:0] bad);
        for (int k = 0; k < len; k++) begin
            @(posedge clk); #1;
            for (int ch = 0; ch < 16; ch++) begin
                logic [15:0] w = wv(seed, ch);
                lane_in[ch] = (2*k < 16) ? w[15-2*k] : 1'b0;
            end
            @(negedge clk); #1;
            for (int ch = 0; ch < 16; ch++) begin
                logic [15:0] w = wv(seed, ch);
                lane_in[ch] = (2*k+1 < 16) ? w[14-2*k] : 1'b0;
            end
            frame_in = ((k < len/2) ? 8'hFF : 8'h00) ^ bad;
        end
    endtask

    task automatic t_reset();
        apply_reset();
        @(posedge clk); #1;
        chk("R1 valid", 256'(sample_valid), 256'(0));
        chk("R1 locked", 256'(locked), 256'(0));
        chk("R1 frame_err", 256'(frame_err), 256'(0));
        chk("R1 mismatch", 256'(mismatch), 256'(0));
    endtask

    task automatic t_basic();
        apply_reset();
        mod_count = 4'd8; vote_en = 1'b0;
        send(1, 8, 8'h00);
        send(2, 8, 8'h00);
        chk("R4 no word before lock", 256'(cap_n), 256'(0));
        chk("R4 not locked after one period", 256'(locked), 256'(0));
        send(3, 8, 8'h00);
        chk("R4 locked after two periods", 256'(locked), 256'(1));
        send(4, 8, 8'h00);
        send(5, 8, 8'h00);
        chk("R3 word count", 256'(cap_n), 256'(3));
        chk("R2 word s2", cap[0], exp_vec(2, 8));
        chk("R2 word s3", cap[1], exp_vec(3, 8));
        chk("R3 word s4", cap[2], exp_vec(4, 8));
        chk("R3 single-cycle strobe", 256'(dbl_valid), 256'(0));
        chk("R5 no error on good stream", 256'(err_n), 256'(0));
        idle(12);
        chk("R6 long period error", 256'(err_n), 256'(1));
        chk("R6 lock dropped", 256'(locked), 256'(0));
        chk("R6 no extra word", 256'(cap_n), 256'(3));
    endtask

    task automatic t_short();
        apply_reset();
        mod_count = 4'd8; vote_en = 1'b0;
        send(11, 8, 8'h00);
        send(12, 8, 8'h00);
        send(13, 8, 8'h00);
        send(14, 6, 8'h00);
        send(15, 8, 8'h00);
        chk("R5 short period error", 256'(err_n), 256'(1));
        chk("R5 lock dropped", 256'(locked), 256'(0));
        chk("R5 no word at bad boundary", 256'(cap_n), 256'(2));
        send(16, 8, 8'h00);
        chk("R5 no relock after one period", 256'(locked), 256'(0));
        send(17, 8, 8'h00);
        send(18, 8, 8'h00);
        chk("R5 relock word count", 256'(cap_n), 256'(4));
        chk("R5 word s13", cap[1], exp_vec(13, 8));
        chk("R5 word s16", cap[2], exp_vec(16, 8));
        chk("R5 word s17", cap[3], exp_vec(17, 8));
        idle(12);
    endtask

    task automatic t_count();
        apply_reset();
        mod_count = 4'd3; vote_en = 1'b0;
        for (int s = 21; s <= 24; s++) send(s, 8, 8'hF8);
        chk("R7 word count", 256'(cap_n), 256'(2));
        chk("R7 inactive zero s22", cap[0], exp_vec(22, 3));
        chk("R7 inactive zero s23", cap[1], exp_vec(23, 3));
        chk("R7 inactive no flags", 256'(mismatch), 256'(0));
        idle(12);
    endtask

    task automatic t_vote();
        apply_reset();
        mod_count = 4'd8; vote_en = 1'b1;
        for (int s = 31; s <= 34; s++) send(s, 8, 8'h02);
        chk("R8 vote corrects module 1", cap[0], exp_vec(32, 8));
        chk("R9 flag module 1", 256'(mismatch), 256'(8'h02));
        idle(12);
        chk("R9 flag stays set", 256'(mismatch), 256'(8'h02));
        @(negedge clk); #1; mismatch_clr = 1'b1;
        @(negedge clk); #1; mismatch_clr = 1'b0;
        chk("R10 clear", 256'(mismatch), 256'(0));

        apply_reset();
        for (int s = 41; s <= 44; s++) send(s, 8, 8'h01);
        chk("R8 vote corrects module 0", cap[0], exp_vec(42, 8));
        chk("R9 flag module 0", 256'(mismatch), 256'(8'h01));
        idle(12);
    endtask

    task automatic t_novote();
        apply_reset();
        mod_count = 4'd8; vote_en = 1'b0;
        for (int s = 51; s <= 53; s++) send(s, 8, 8'h01);
        chk("R8 module 0 is reference", 256'(mismatch), 256'(8'hFE));
        idle(12);

        apply_reset();
        mod_count = 4'd2; vote_en = 1'b1;
        for (int s = 61; s <= 63; s++) send(s, 8, 8'h01);
        chk("R8 no vote below three modules", 256'(mismatch), 256'(8'h02));
        idle(12);
    endtask

    task automatic t_clear_prio();
        apply_reset();
        mod_count = 4'd8; vote_en = 1'b1;
        @(negedge clk); #1; frame_in = 8'h02;
        @(negedge clk); #1;
        chk("R9 static disagreement", 256'(mismatch), 256'(8'h02));
        mismatch_clr = 1'b1;
        @(posedge clk); #1;
        chk("R10 clear wins over set", 256'(mismatch), 256'(0));
        @(negedge clk); #1; mismatch_clr = 1'b0;
        @(posedge clk); #1;
        chk("R9 sets again after clear", 256'(mismatch), 256'(8'h02));
        frame_in = 8'h00;
    endtask

    initial begin
        t_reset();
        t_basic();
        t_short();
        t_count();
        t_vote();
        t_novote();
        t_clear_prio();
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
    end

endmodule